// File: doc/BRIEF.md
# Slave Port Ownership Arbiter

This block decides which of several bus masters owns one slave port of a crossbar. Every master raises a request line when it wants the slave. The arbiter picks a winner, which keeps the slave until it signals the end of its transaction. Every other requester is held off with a stall line until then. Address decode, data steering and the bus protocol are handled elsewhere. This block only produces the ownership decision.

A mode input chooses the policy at run time. With the mode low, a lower master number always wins. With the mode high, the masters take turns in rotation, starting with the master after the one granted last. Each master also has an elevation input. A requester whose elevation is high beats every requester without it. Among several elevated requesters, the active policy decides. A decision is taken only while the slave is unowned, or on the clock edge where the owner signals completion. A decision never changes mid-transaction.

Top module: `slv_port_arb`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `grant_o` and `stall_o` are all zero. Reset selects the fixed policy state: the rotation pointer is set to the highest master index, so the first rotating decision starts its search at master 0.
- R2: With `rr_mode_i` = 0 and no elevated requester, the requesting master with the lowest index wins. The grant appears on `grant_o` one clock after the request is sampled on an unowned slave.
- R3: `grant_o` is one-hot or all zero. Bit i set means that master i owns the slave.
- R4: Once a master is granted, `grant_o` stays unchanged until `done_i` is sampled high. This holds even if the owner drops its request, other masters request, or `elev_i` or `rr_mode_i` change.
- R5: On an edge where `done_i` is high and the slave is owned, a new decision is made among the requests sampled on that edge, and the new grant shows the next cycle. If nothing is requested, `grant_o` becomes zero. `done_i` while the slave is unowned changes nothing.
- R6: `stall_o[i]` is high exactly when `req_i[i]` is high and `grant_o[i]` is low.
- R7: With `rr_mode_i` = 1, the search starts at the master just after the last granted one, wraps past the highest index, and takes the first requester found.
- R8: If any requesting master has its `elev_i` bit high, only elevated requesters can win. Ties among them are settled by the active policy (R2 or R7).
- R9: The rotation pointer moves to the winner on every grant, in either policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode_i | input | 1 | Policy select: 0 fixed by index, 1 rotating |
| req_i | input | N_MST | Per-master request |
| elev_i | input | N_MST | Per-master temporary priority elevation |
| done_i | input | 1 | Current owner finishes its transaction on this edge |
| grant_o | output | N_MST | One-hot owner of the slave |
| stall_o | output | N_MST | Per-master stall: requesting but not owning |

## Verification
The fixed policy is driven with overlapping request sets. These show that the lowest index wins and that a higher-priority arrival does not preempt a running owner. Rotating mode is run with all masters requesting, then with a sparse pair. The all-masters case shows the pointer walking in order. The sparse pair shows wrap-around and the skipping of idle masters. Elevation patterns use a single elevated master, then two elevated masters, in each policy. These separate the override itself from the tie-break that follows the policy. Mid-transaction changes of the mode and elevation inputs confirm that a decision happens only on completion.

// File: rtl/slv_port_arb_pkg.sv
package slv_port_arb_pkg;

    typedef enum logic {
        POL_FIXED = 1'b0,
        POL_ROTATE = 1'b1
    } arb_policy_e;

    localparam int MAX_MST = 64;

    // index of the lowest set bit, 0 when none is set
    function automatic int lowest_set(input logic [MAX_MST-1:0] v);
        int r;
        r = 0;
        for (int i = MAX_MST - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/arb_elev_filter.sv
module arb_elev_filter #(
    parameter int N_MST = 4
) (
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] elev_i,
    output logic [N_MST-1:0] cand_o
);
    logic [N_MST-1:0] hot;

    assign hot    = req_i & elev_i;
    assign cand_o = (|hot) ? hot : req_i;
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import slv_port_arb_pkg::*;
#(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] cand_i,
    input  logic [IDX_W-1:0] last_i,
    input  arb_policy_e      policy_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] win_o
);
    logic [N_MST-1:0] above;
    logic [N_MST-1:0] masked;
    logic [MAX_MST-1:0] cand_w;
    logic [MAX_MST-1:0] masked_w;

    for (genvar g = 0; g < N_MST; g++) begin : g_above
        assign above[g] = (IDX_W'(g) > last_i);
    end

    assign masked   = cand_i & above;
    assign cand_w   = MAX_MST'(cand_i);
    assign masked_w = MAX_MST'(masked);
    assign hit_o    = |cand_i;

    always_comb begin
        if (policy_i == POL_ROTATE && (|masked)) begin
            win_o = IDX_W'(lowest_set(masked_w));
        end else begin
            win_o = IDX_W'(lowest_set(cand_w));
        end
    end
endmodule

// File: rtl/arb_owner.sv
module arb_owner #(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             decide_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] win_i,
    output logic             own_vld_o,
    output logic [IDX_W-1:0] last_o,
    output logic [N_MST-1:0] grant_o
);
    logic [IDX_W-1:0] own_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_vld_o <= 1'b0;
            own_idx   <= '0;
            last_o    <= IDX_W'(N_MST - 1);
        end else if (decide_i) begin
            own_vld_o <= hit_i;
            if (hit_i) begin
                own_idx <= win_i;
                last_o  <= win_i;
            end
        end
    end

    for (genvar g = 0; g < N_MST; g++) begin : g_gnt
        assign grant_o[g] = own_vld_o && (own_idx == IDX_W'(g));
    end
endmodule

// File: rtl/slv_port_arb.sv
module slv_port_arb
    import slv_port_arb_pkg::*;
#(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rr_mode_i,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] elev_i,
    input  logic             done_i,
    output logic [N_MST-1:0] grant_o,
    output logic [N_MST-1:0] stall_o
);
    logic [N_MST-1:0] cand;
    logic             hit;
    logic [IDX_W-1:0] win;
    logic [IDX_W-1:0] last;
    logic             own_vld;
    logic             decide;
    arb_policy_e      policy;

    assign policy = rr_mode_i ? POL_ROTATE : POL_FIXED;
    assign decide = !own_vld || done_i;

    arb_elev_filter #(.N_MST(N_MST)) u_filt (
        .req_i  (req_i),
        .elev_i (elev_i),
        .cand_o (cand)
    );

    arb_pick #(.N_MST(N_MST)) u_pick (
        .cand_i   (cand),
        .last_i   (last),
        .policy_i (policy),
        .hit_o    (hit),
        .win_o    (win)
    );

    arb_owner #(.N_MST(N_MST)) u_own (
        .clk       (clk),
        .rst       (rst),
        .decide_i  (decide),
        .hit_i     (hit),
        .win_i     (win),
        .own_vld_o (own_vld),
        .last_o    (last),
        .grant_o   (grant_o)
    );

    for (genvar g = 0; g < N_MST; g++) begin : g_stall
        assign stall_o[g] = req_i[g] && !grant_o[g];
    end
endmodule

// File: rtl/slv_port_arb_chk.sv
module slv_port_arb_chk #(
    parameter int N_MST = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rr_mode_i,
    input logic [N_MST-1:0] req_i,
    input logic [N_MST-1:0] elev_i,
    input logic             done_i,
    input logic [N_MST-1:0] grant_o,
    input logic [N_MST-1:0] stall_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (grant_o == '0));

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R4
    owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((grant_o != '0) && !done_i) |=> $stable(grant_o));

    // R6
    stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ((stall_o & grant_o) == '0) && ((stall_o & ~req_i) == '0));

    // R5
    idle_take_chk: assert property (@(posedge clk) disable iff (rst)
        ((grant_o == '0) && (req_i != '0)) |=> (grant_o != '0));

    // R8
    elev_win_chk: assert property (@(posedge clk) disable iff (rst)
        (((grant_o == '0) || done_i) && ((req_i & elev_i) != '0))
        |=> ((grant_o & $past(req_i & elev_i)) != '0));

    // R2
    fixed_top_chk: assert property (@(posedge clk) disable iff (rst)
        (((grant_o == '0) || done_i) && !rr_mode_i
         && ((req_i & elev_i) == '0) && req_i[0]) |=> grant_o[0]);
endmodule

bind slv_port_arb slv_port_arb_chk #(.N_MST(N_MST)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rr_mode_i (rr_mode_i),
    .req_i     (req_i),
    .elev_i    (elev_i),
    .done_i    (done_i),
    .grant_o   (grant_o),
    .stall_o   (stall_o)
);

// File: tb/test_slv_port_arb.sv
module test_slv_port_arb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rr_mode_i;
    logic [3:0] req_i;
    logic [3:0] elev_i;
    logic       done_i;
    logic [3:0] grant_o;
    logic [3:0] stall_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    slv_port_arb #(.N_MST(4)) i_slv_port_arb (
        .clk       (clk),
        .rst       (rst),
        .rr_mode_i (rr_mode_i),
        .req_i     (req_i),
        .elev_i    (elev_i),
        .done_i    (done_i),
        .grant_o   (grant_o),
        .stall_o   (stall_o)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // drive at falling edge, sample 1 ns after the next rising edge
    task automatic step(input logic [3:0] rq, input logic [3:0] ev,
                        input logic rr, input logic dn);
        @(negedge clk);
        req_i = rq; elev_i = ev; rr_mode_i = rr; done_i = dn;
        @(posedge clk);
        #1;
        done_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_i = '0; elev_i = '0; rr_mode_i = 1'b0; done_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 grant in reset", grant_o, 4'b0000);
        chk("R1 stall in reset", stall_o, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 grant after reset", grant_o, 4'b0000);
    endtask

    task automatic t_fixed();
        do_reset();
        step(4'b1110, 4'b0000, 1'b0, 1'b0);
        chk("R2 lowest requester", grant_o, 4'b0010);
        chk("R6 stall others", stall_o, 4'b1100);
        step(4'b1111, 4'b0000, 1'b0, 1'b0);
        chk("R4 no preempt by master 0", grant_o, 4'b0010);
        chk("R6 master 0 stalled", stall_o, 4'b1101);
        step(4'b1101, 4'b0000, 1'b0, 1'b0);
        chk("R4 owner drops request, still owns", grant_o, 4'b0010);
        step(4'b1101, 4'b0000, 1'b0, 1'b1);
        chk("R5 rearbitrate on done", grant_o, 4'b0001);
        chk("R6 stall after handover", stall_o, 4'b1100);
        step(4'b0000, 4'b0000, 1'b0, 1'b1);
        chk("R5 done with no requests", grant_o, 4'b0000);
        step(4'b0000, 4'b0000, 1'b0, 1'b1);
        chk("R5 done while idle", grant_o, 4'b0000);
        chk("R6 no stall when idle", stall_o, 4'b0000);
    endtask

    task automatic t_rotate();
        do_reset();
        step(4'b1111, 4'b0000, 1'b1, 1'b0);
        chk("R7 R9 first rotating pick is master 0", grant_o, 4'b0001);
        step(4'b1111, 4'b0000, 1'b1, 1'b1);
        chk("R7 next master 1", grant_o, 4'b0010);
        step(4'b1111, 4'b0000, 1'b1, 1'b1);
        chk("R7 next master 2", grant_o, 4'b0100);
        step(4'b1111, 4'b0000, 1'b1, 1'b1);
        chk("R7 next master 3", grant_o, 4'b1000);
        step(4'b1111, 4'b0000, 1'b1, 1'b1);
        chk("R7 wrap to master 0", grant_o, 4'b0001);
        step(4'b1010, 4'b0000, 1'b1, 1'b1);
        chk("R7 sparse pick 1", grant_o, 4'b0010);
        step(4'b1010, 4'b0000, 1'b1, 1'b1);
        chk("R7 sparse pick 3", grant_o, 4'b1000);
        step(4'b1010, 4'b0000, 1'b1, 1'b1);
        chk("R7 sparse wrap to 1", grant_o, 4'b0010);
        step(4'b1111, 4'b0000, 1'b0, 1'b0);
        chk("R4 mode change mid transaction", grant_o, 4'b0010);
        step(4'b1111, 4'b0000, 1'b0, 1'b1);
        chk("R2 fixed policy after switch back", grant_o, 4'b0001);
    endtask

    task automatic t_elev();
        do_reset();
        step(4'b1111, 4'b1000, 1'b0, 1'b0);
        chk("R8 elevated master 3 wins", grant_o, 4'b1000);
        step(4'b1111, 4'b1010, 1'b0, 1'b1);
        chk("R8 fixed tie among elevated", grant_o, 4'b0010);
        step(4'b1111, 4'b0000, 1'b0, 1'b1);
        chk("R8 no elevation, lowest wins", grant_o, 4'b0001);
        step(4'b1111, 4'b0101, 1'b1, 1'b1);
        chk("R8 R9 rotating tie from master 1", grant_o, 4'b0100);
        step(4'b1111, 4'b0101, 1'b1, 1'b1);
        chk("R8 rotating tie wraps to master 0", grant_o, 4'b0001);
        step(4'b1111, 4'b1000, 1'b1, 1'b0);
        chk("R4 elevation mid transaction", grant_o, 4'b0001);
        step(4'b0111, 4'b1000, 1'b1, 1'b1);
        chk("R8 elevated but idle master ignored", grant_o, 4'b0010);
    endtask

    initial begin
        rst = 1'b1; req_i = '0; elev_i = '0; rr_mode_i = 1'b0; done_i = 1'b0;
        t_fixed();
        t_rotate();
        t_elev();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule